// File: doc/BRIEF.md
# Branch-on-bit-test decode and execute unit

This unit recognises a small family of conditional branches that look at a single bit of a 64-bit general register. Each accepted instruction word arrives with its program counter and a valid strobe. The unit decodes the source register index and drives it to the register file. The operand comes back in the same cycle. The unit then selects the bit named by the instruction and compares it with the polarity the opcode asks for. One cycle later it reports whether the branch is taken and where it goes.

The unit also remembers whether the instruction it is about to see sits in the delay slot of one of its own branches. A branch found in that slot is not evaluated. It raises a reserved-instruction exception instead. Words with any other major opcode pass through as not decoded by this unit. They set no flags, and they act only as the instruction that ends a pending delay slot.

Top module: `bitbr_unit`

## Requirements
- R1: The unit decodes a word when insn_i[31:26] is one of 110010, 110110, 111010 or 111110. One cycle after such a word is accepted (in_valid_i=1 at a rising edge), hit_o=1.
- R2: Polarity comes from insn_i[29]. With a 1, the branch is taken when the tested bit is 1. With a 0, the branch is taken when the tested bit is 0.
- R3: The tested bit position is {insn_i[28], insn_i[20:16]} and covers 0 to 63.
- R4: rf_idx_o equals insn_i[25:21] in the same cycle. The operand on rf_data_i is sampled at the accepting edge.
- R5: For a decoded branch that raises no exception, target_o = pc_i + 4 + (sign-extended insn_i[15:0] × 4), modulo 2^64, whether or not the branch is taken. In every other case target_o is 0.
- R6: A decoded branch accepted while dslot_o=1 gives rsvd_exc_o=1, taken_o=0 and target_o=0, and it does not set dslot_o.
- R7: dslot_o becomes 1 after a decoded branch is accepted with dslot_o=0, whether or not the branch is taken. It returns to 0 after the next accepted instruction of any kind. It holds its value while in_valid_i=0.
- R8: A word that is not decoded gives hit_o=0, taken_o=0, rsvd_exc_o=0 and target_o=0, and it never sets dslot_o.
- R9: out_valid_o is in_valid_i delayed by one cycle. While out_valid_o=0, the outputs hit_o, taken_o, rsvd_exc_o and target_o are 0.
- R10: While rst_ni=0, every output register and dslot_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Instruction word is offered and accepted this cycle |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction word |
| rf_idx_o | output | 5 | Source register index for the register file |
| rf_data_i | input | 64 | Register operand returned for rf_idx_o |
| out_valid_o | output | 1 | Result outputs refer to the word accepted one cycle earlier |
| hit_o | output | 1 | Word was decoded by this unit |
| taken_o | output | 1 | Branch condition holds |
| target_o | output | 64 | Branch destination |
| rsvd_exc_o | output | 1 | Reserved-instruction exception: branch found in a delay slot |
| dslot_o | output | 1 | Next accepted instruction is a delay slot |

## Verification
The hardest case to reach from the ports is a decoded branch sitting directly in the delay slot of another branch. A variant of that case has idle cycles between the two, and the pending flag must survive them. The random stream draws about two thirds of its words from the four opcodes and inserts random idle gaps, so back-to-back branches and branches after gaps occur often. Directed sequences force a branch right after a branch and after idle cycles. They also cover bit positions 0, 31, 32 and 63, the extreme offsets, and a program counter that wraps.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;

    localparam int XLEN      = 64;
    localparam int ILEN      = 32;
    localparam int RIDX_W    = 5;
    localparam int OFF_W     = 16;
    localparam int BITPOS_W  = $clog2(XLEN);
    localparam int NUM_OPC   = 4;

    // Fixed bits of the opcode family: [31:30]=11, [27:26]=10
    localparam logic [1:0] OPC_HI = 2'b11;
    localparam logic [1:0] OPC_LO = 2'b10;

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic             taken;
        logic             exc;
        logic [XLEN-1:0]  target;
        logic             dslot;
    } bitbr_state_t;

endpackage

// File: rtl/bitbr_decode.sv
module bitbr_decode
    import bitbr_pkg::*;
#(
    parameter int IW   = ILEN,
    parameter int RW   = RIDX_W,
    parameter int OW   = OFF_W,
    parameter int PW   = BITPOS_W
) (
    input  logic [IW-1:0] insn_i,
    output logic          hit_o,
    output logic          pol_o,
    output logic [PW-1:0] bitpos_o,
    output logic [RW-1:0] rs_o,
    output logic [OW-1:0] off_o
);

    logic [NUM_OPC-1:0] match;

    // One comparator per family member: index bit 1 is polarity, bit 0 is the upper-half select
    for (genvar i = 0; i < NUM_OPC; i++) begin : g_opc
        localparam logic [1:0] SEL = 2'(i);
        assign match[i] = (insn_i[31:26] == {OPC_HI, SEL[1], SEL[0], OPC_LO});
    end

    assign hit_o    = |match;
    assign pol_o    = insn_i[29];
    assign bitpos_o = PW'({insn_i[28], insn_i[20:16]});
    assign rs_o     = insn_i[25:21];
    assign off_o    = insn_i[OW-1:0];

endmodule

// File: rtl/bitbr_bittest.sv
module bitbr_bittest
    import bitbr_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int PW = BITPOS_W
) (
    input  logic [DW-1:0] data_i,
    input  logic [PW-1:0] pos_i,
    input  logic          pol_i,
    output logic          cond_o
);

    logic sel_bit;

    assign sel_bit = data_i[pos_i];
    assign cond_o  = (sel_bit == pol_i);

endmodule

// File: rtl/bitbr_target.sv
module bitbr_target
    import bitbr_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int OW = OFF_W
) (
    input  logic [AW-1:0] pc_i,
    input  logic [OW-1:0] off_i,
    output logic [AW-1:0] target_o
);

    localparam int EXT_W = AW - OW - 2;

    logic [AW-1:0] disp;

    assign disp     = {{EXT_W{off_i[OW-1]}}, off_i, 2'b00};
    assign target_o = pc_i + AW'(4) + disp;

endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit
    import bitbr_pkg::*;
#(
    parameter int DW = XLEN,
    parameter int IW = ILEN,
    parameter int RW = RIDX_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          in_valid_i,
    input  logic [IW-1:0] insn_i,
    input  logic [DW-1:0] pc_i,
    output logic [RW-1:0] rf_idx_o,
    input  logic [DW-1:0] rf_data_i,
    output logic          out_valid_o,
    output logic          hit_o,
    output logic          taken_o,
    output logic [DW-1:0] target_o,
    output logic          rsvd_exc_o,
    output logic          dslot_o
);

    localparam int PW = $clog2(DW);

    logic          dec_hit;
    logic          dec_pol;
    logic [PW-1:0] dec_pos;
    logic [OFF_W-1:0] dec_off;
    logic          cond;
    logic [DW-1:0] tgt;

    bitbr_state_t st_d, st_q;

    bitbr_decode #(.IW(IW), .RW(RW), .OW(OFF_W), .PW(PW)) u_dec (
        .insn_i   (insn_i),
        .hit_o    (dec_hit),
        .pol_o    (dec_pol),
        .bitpos_o (dec_pos),
        .rs_o     (rf_idx_o),
        .off_o    (dec_off)
    );

    bitbr_bittest #(.DW(DW), .PW(PW)) u_test (
        .data_i (rf_data_i),
        .pos_i  (dec_pos),
        .pol_i  (dec_pol),
        .cond_o (cond)
    );

    bitbr_target #(.AW(DW), .OW(OFF_W)) u_tgt (
        .pc_i     (pc_i),
        .off_i    (dec_off),
        .target_o (tgt)
    );

    always_comb begin
        st_d        = '0;
        st_d.dslot  = st_q.dslot;
        st_d.vld    = in_valid_i;
        if (in_valid_i) begin
            st_d.hit   = dec_hit;
            // Any accepted word ends a pending delay slot
            st_d.dslot = 1'b0;
            if (dec_hit) begin
                if (st_q.dslot) begin
                    st_d.exc = 1'b1;
                end else begin
                    st_d.taken  = cond;
                    st_d.target = tgt;
                    st_d.dslot  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.vld;
    assign hit_o       = st_q.hit;
    assign taken_o     = st_q.taken;
    assign target_o    = st_q.target;
    assign rsvd_exc_o  = st_q.exc;
    assign dslot_o     = st_q.dslot;

endmodule

// File: rtl/bitbr_unit_chk.sv
module bitbr_unit_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        in_valid_i,
    input logic [31:0] insn_i,
    input logic        out_valid_o,
    input logic        hit_o,
    input logic        taken_o,
    input logic [63:0] target_o,
    input logic        rsvd_exc_o,
    input logic        dslot_o
);

    logic fam;
    assign fam = (insn_i[31:30] == 2'b11) && (insn_i[27:26] == 2'b10);

    AST_HIT_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && fam |=> out_valid_o && hit_o); // R1

    AST_SLOT_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && fam && dslot_o |=> rsvd_exc_o && !taken_o && target_o == 64'd0); // R6

    AST_SLOT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && fam && !dslot_o |=> dslot_o); // R7

    AST_SLOT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && dslot_o |=> !dslot_o); // R7

    AST_SLOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(dslot_o)); // R7

    AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i && !fam |=> !hit_o && !taken_o && !rsvd_exc_o && !dslot_o); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o && !hit_o && !taken_o && !rsvd_exc_o); // R9

    AST_EXC_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsvd_exc_o |-> hit_o && !taken_o); // R6

endmodule

bind bitbr_unit bitbr_unit_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .insn_i      (insn_i),
    .out_valid_o (out_valid_o),
    .hit_o       (hit_o),
    .taken_o     (taken_o),
    .target_o    (target_o),
    .rsvd_exc_o  (rsvd_exc_o),
    .dslot_o     (dslot_o)
);

// File: tb/bitbr_unit_tb_top.sv
`timescale 1ns/1ps
module bitbr_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] pc = '0;
    logic [4:0]  rf_idx;
    logic [63:0] rf_data;
    logic        out_valid, hit, taken, exc, dslot;
    logic [63:0] target;

    logic [63:0] regs [32];
    int checks = 0;
    int fails  = 0;
    bit model_dslot = 1'b0;

    assign rf_data = regs[rf_idx];

    always #(CLK_PERIOD/2) clk = ~clk;

    bitbr_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .insn_i(insn), .pc_i(pc),
        .rf_idx_o(rf_idx), .rf_data_i(rf_data), .out_valid_o(out_valid), .hit_o(hit),
        .taken_o(taken), .target_o(target), .rsvd_exc_o(exc), .dslot_o(dslot)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit is_fam(input logic [31:0] w);
        return (w[31:26] == 6'b110010) || (w[31:26] == 6'b110110) ||
               (w[31:26] == 6'b111010) || (w[31:26] == 6'b111110);
    endfunction

    function automatic logic [63:0] exp_tgt(input logic [63:0] p, input logic [15:0] o);
        logic signed [63:0] d;
        d = 64'(signed'(o)) * 64'sd4;
        return p + 64'd4 + d;
    endfunction

    // One accepted word, checked one edge later
    task automatic apply(input logic [31:0] w, input logic [63:0] p);
        bit e_hit, e_taken, e_exc, e_ds;
        logic [63:0] e_tgt;
        int pos;
        @(negedge clk);
        insn = w; pc = p; in_valid = 1'b1;
        #1;
        chk("R4", "rf_idx", 64'(rf_idx), 64'(w[25:21]));
        e_hit = is_fam(w); e_taken = 0; e_exc = 0; e_tgt = '0; e_ds = 0;
        if (e_hit) begin
            if (model_dslot) e_exc = 1;
            else begin
                pos = {w[28], w[20:16]};
                e_taken = (regs[w[25:21]][pos] == w[29]);
                e_tgt = exp_tgt(p, w[15:0]);
                e_ds = 1;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk("R9", "out_valid", 64'(out_valid), 64'd1);
        chk("R1", "hit", 64'(hit), 64'(e_hit));
        chk(e_hit ? "R2" : "R8", "taken", 64'(taken), 64'(e_taken));
        chk("R6", "exc", 64'(exc), 64'(e_exc));
        chk("R5", "target", target, e_tgt);
        chk("R7", "dslot", 64'(dslot), 64'(e_ds));
        model_dslot = e_ds;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); in_valid = 1'b0; insn = $urandom;
            @(posedge clk); #1;
            chk("R9", "idle out_valid", 64'(out_valid), 64'd0);
            chk("R9", "idle hit/taken/exc", {61'd0, hit, taken, exc}, 64'd0);
            chk("R7", "idle dslot hold", 64'(dslot), 64'(model_dslot));
        end
    endtask

    function automatic logic [31:0] mk(input bit set, input int pos, input int rs, input logic [15:0] off);
        logic [31:0] w;
        w = {2'b11, set, pos[5], 2'b10, rs[4:0], pos[4:0], off};
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int r = 0; r < 32; r++) regs[r] = {$urandom, $urandom};
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "reset outputs", {59'd0, out_valid, hit, taken, exc, dslot}, 64'd0);
        chk("R10", "reset target", target, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed: edge bit positions, both polarities (R2, R3)
        regs[3] = 64'h8000_0001_0000_0001;
        apply(mk(1, 0, 3, 16'h0010), 64'h1000); apply(32'h0, 64'h1004);
        apply(mk(0, 0, 3, 16'h0010), 64'h1000); apply(32'h0, 64'h1004);
        apply(mk(1, 63, 3, 16'h0001), 64'h2000); apply(32'h0, 64'h2004);
        apply(mk(1, 32, 3, 16'h0001), 64'h2000); apply(32'h0, 64'h2004);
        apply(mk(0, 31, 3, 16'h0001), 64'h2000); apply(32'h0, 64'h2004);
        // Offsets and wrap (R5)
        apply(mk(1, 5, 7, 16'h8000), 64'h0000_0000_0001_0000); apply(32'h0, 64'h4);
        apply(mk(1, 5, 7, 16'h7fff), 64'hffff_ffff_ffff_fffc); apply(32'h0, 64'h4);
        // Branch directly in a slot, and after idle gap (R6, R7)
        apply(mk(1, 2, 4, 16'h0004), 64'h3000);
        apply(mk(0, 9, 5, 16'h0004), 64'h3004);
        apply(mk(1, 2, 4, 16'h0004), 64'h3008);
        idle(3);
        apply(mk(1, 2, 4, 16'h0004), 64'h300c);
        apply(32'hc800_0000 ^ 32'h0400_0000, 64'h3010); // opcode 110011: not decoded (R8)
        apply(32'h2400_0000, 64'h3014); // not decoded, no slot pending (R8)

        for (int n = 0; n < N_RANDOM; n++) begin
            logic [31:0] w;
            for (int r = 0; r < 32; r++) if ($urandom_range(0, 7) == 0) regs[r] = {$urandom, $urandom};
            w = $urandom;
            if ($urandom_range(0, 2) != 0) w[31:26] = {2'b11, 1'($urandom), 1'($urandom), 2'b10};
            apply(w, {$urandom, $urandom});
            if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule